// File: doc/BRIEF.md
# Dual-Channel Converter Sample Front End

This block sits between a 32-bit register bus and a two-channel 12-bit digital-to-analog converter. Software writes a sample through one of several data views: right-justified 12-bit, left-justified 12-bit, or a byte. Each view exists per channel and also as a dual view that loads both channels with one bus write. The sample lands in the channel's holding register. It reaches that channel's output bus only when the channel fires. A channel with its trigger disabled fires on the clock after every write. A channel with its trigger enabled fires on a rising edge of the trigger input it selects, or when software requests a trigger.

The block also holds the per-channel control state and applies its write guards. The calibration-enable bit and the mode field are protected by the channel's current state. A sticky underrun flag is set by a hardware event and cleared by writing 1 to it.

Register map (word offsets):
- Control: 0x00. Channel c uses bits 16c+6..16c. Bit 16c is enable, bit 16c+1 is trigger enable, bits 16c+5..16c+2 are the trigger select, and bit 16c+6 is calibration enable.
- Mode: 0x04, a 3-bit field at bits 16c+2..16c.
- Software trigger: 0x08, bit c.
- Flags: 0x0C, underrun flag at bit 16c.
- Data views: channel 1 at 0x10, 0x14 and 0x18; channel 2 at 0x20, 0x24 and 0x28; both channels at 0x30, 0x34 and 0x38. In each group the offsets are right 12-bit, left 12-bit and byte, in that order.
- Outputs: 0x40 and 0x44, read-only.

Reads return the stored value in the same layout.

Top module: `dacfe_top`

## Requirements
- R1: After reset, every register reads 0 and both output buses are 0.
- R2: A right-justified 12-bit write takes the sample from bus bits 11:0 (offsets 0x10 and 0x20).
- R3: A left-justified 12-bit write takes the sample from bus bits 15:4 (offsets 0x14 and 0x24).
- R4: A byte write takes bus bits 7:0 and stores them shifted up by four, so byte 0xFF gives 0xFF0 (offsets 0x18 and 0x28).
- R5: The dual views load channel 1 from the low half-word. They load channel 2 from bits 27:16 (0x30), 31:20 (0x34) or 15:8 (0x38).
- R6: For a channel with enable=1 and trigger enable=0, the output takes the holding value on the clock after the write.
- R7: For a channel with enable=1 and trigger enable=1, the output changes only on a rising edge of the trigger input chosen by the 4-bit select (control bits 16c+5..16c+2). Edges on other inputs have no effect on the output.
- R8: While a channel's enable bit is 0, its output bus keeps its value whatever is written.
- R9: Writing 1 to bit c at 0x08 sets a pending bit, which reads back at 0x08. The output copies the holding value on the next clock, and the pending bit clears one clock after that copy.
- R10: A write to the calibration-enable bit takes effect only if the channel's enable bit was 0 before the write. Otherwise the bit keeps its value.
- R11: A write to a channel's mode field takes effect only if that channel's enable and calibration-enable bits are both 0. Otherwise the field keeps its value.
- R12: The underrun flag is set by a pulse on `udr_evt[c]` and cleared by writing 1 to bit 16c at 0x0C. Writing 1 to the other channel's bit leaves it unchanged, and a set in the same cycle as a clear wins.
- R13: The output registers at 0x40 and 0x44 return the current output in bits 11:0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| trig_in | input | 16 | Hardware trigger inputs, rising edge active |
| udr_evt | input | 2 | Per-channel underrun event pulses |
| dac_out1 | output | 12 | Channel 1 output code |
| dac_out2 | output | 12 | Channel 2 output code |

## Verification
Some rules are checked on every cycle by the assertions:
- the frozen output of a disabled channel;
- the one-clock follow of the holding value in untriggered mode;
- the state guards on the calibration bit and the mode field;
- the self-clear of the software trigger;
- the set and clear behaviour of the underrun flag.

Other behaviour can only be shown by the bench's scenarios. These are the exact bit positions of each alignment view and dual view, the selectivity of the trigger select among sixteen inputs, the read-only output registers, and the exact cycle in which a software trigger is seen pending and then gone. A scoreboard matches every output change against the sample the driver predicted. An output that changes when it should not is therefore reported as well.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;

   localparam int unsigned REG_AW    = 8;
   localparam int unsigned TSEL_W    = 4;
   localparam int unsigned CH_STRIDE = 16;

   // fixed register offsets
   localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
   localparam logic [REG_AW-1:0] OFS_MODE  = 8'h04;
   localparam logic [REG_AW-1:0] OFS_SWTRG = 8'h08;
   localparam logic [REG_AW-1:0] OFS_FLAGS = 8'h0C;

   // address groups: addr[7:4]
   localparam logic [3:0] GRP_REGS = 4'h0;
   localparam logic [3:0] GRP_DUAL = 4'h3;
   localparam logic [3:0] GRP_OUT  = 4'h4;

   // data view format: addr[3:2] inside a data group
   typedef enum logic [1:0] {
      FMT_RIGHT = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_BYTE  = 2'd2,
      FMT_NONE  = 2'd3
   } fmt_e;

   // per-channel control slice, packed so bit 0 is the enable
   typedef struct packed {
      logic              cal;
      logic [TSEL_W-1:0] tsel;
      logic              trig_en;
      logic              en;
   } chan_ctl_t;

   localparam int unsigned CTL_W = $bits(chan_ctl_t);

endpackage

// File: rtl/dacfe_wrdec.sv
`timescale 1ns/1ps
module dacfe_wrdec
   import dacfe_pkg::*;
#(
   parameter int DW  = 12,
   parameter int NCH = 2
) (
   input  logic [REG_AW-1:0] addr,
   input  logic              wen,
   input  logic [31:0]       wdata,
   output logic              ctl_we,
   output logic              mode_we,
   output logic              sw_we,
   output logic              flag_we,
   output logic [NCH-1:0]    hold_we,
   output logic [DW-1:0]     hold_val [NCH]
);

   localparam int BYTE_SHIFT = DW - 8;

   // convert one 16-bit half into a DW-bit sample
   function automatic logic [DW-1:0] unpack_view(fmt_e f, logic [15:0] h);
      logic [DW-1:0] v;
      v = '0;
      case (f)
         FMT_RIGHT: v = h[DW-1:0];
         FMT_LEFT:  v = h[15 -: DW];
         default:   v[DW-1 -: 8] = h[7:0];
      endcase
      return v;
   endfunction

   logic [3:0] grp;
   fmt_e       fsel;
   logic       aligned;
   logic       view_ok;

   assign grp     = addr[7:4];
   assign fsel    = fmt_e'(addr[3:2]);
   assign aligned = (addr[1:0] == 2'b00);
   assign view_ok = aligned && (fsel != FMT_NONE);

   assign ctl_we  = wen && (addr == OFS_CTRL);
   assign mode_we = wen && (addr == OFS_MODE);
   assign sw_we   = wen && (addr == OFS_SWTRG);
   assign flag_we = wen && (addr == OFS_FLAGS);

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         logic [15:0] half;
         logic        single_hit;
         logic        dual_hit;
         single_hit = (grp == 4'(c + 1));
         dual_hit   = (grp == GRP_DUAL);
         if (dual_hit && c != 0)
            half = (fsel == FMT_BYTE) ? {8'h00, wdata[15:8]} : wdata[31:16];
         else
            half = wdata[15:0];
         hold_we[c]  = wen && view_ok && (single_hit || dual_hit);
         hold_val[c] = unpack_view(fsel, half);
      end
   end

   if (BYTE_SHIFT < 0) begin : g_bad_width
      $error("dacfe_wrdec: DW must be at least 8");
   end

endmodule

// File: rtl/dacfe_chan.sv
`timescale 1ns/1ps
module dacfe_chan
   import dacfe_pkg::*;
#(
   parameter int DW     = 12,
   parameter int NTRIG  = 16,
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  chan_ctl_t         ctl_wr,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wr,
   input  logic              sw_set,
   input  logic              flag_clr,
   input  logic              flag_evt,
   input  logic              hold_we,
   input  logic [DW-1:0]     hold_wr,
   input  logic [NTRIG-1:0]  trig_now,
   input  logic [NTRIG-1:0]  trig_last,
   output chan_ctl_t         ctl_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              sw_pend,
   output logic              flag_q,
   output logic [DW-1:0]     hold_q,
   output logic [DW-1:0]     out_q
);

   localparam int TRIG_SPAN = 1 << TSEL_W;

   logic [TRIG_SPAN-1:0] now_pad;
   logic [TRIG_SPAN-1:0] last_pad;
   logic                 edge_hit;
   logic                 sw_done;
   logic                 sw_fire;
   logic                 load;

   assign now_pad  = TRIG_SPAN'(trig_now);
   assign last_pad = TRIG_SPAN'(trig_last);
   assign edge_hit = ctl_q.trig_en && now_pad[ctl_q.tsel] && !last_pad[ctl_q.tsel];
   assign sw_fire  = sw_pend && !sw_done && ctl_q.en;
   assign load     = ctl_q.en && (!ctl_q.trig_en || edge_hit || sw_fire);

   // control state with the calibration guard
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_we) begin
         ctl_q.en      <= ctl_wr.en;
         ctl_q.trig_en <= ctl_wr.trig_en;
         ctl_q.tsel    <= ctl_wr.tsel;
         if (!ctl_q.en)
            ctl_q.cal <= ctl_wr.cal;
      end
   end

   // mode field, writable only from the idle state
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (mode_we && !ctl_q.en && !ctl_q.cal)
         mode_q <= mode_wr;
   end

   // holding and output registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         out_q  <= '0;
      end else begin
         if (hold_we)
            hold_q <= hold_wr;
         if (load)
            out_q <= hold_q;
      end
   end

   // software trigger: pending until one clock after its copy
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_pend <= 1'b0;
         sw_done <= 1'b0;
      end else begin
         sw_done <= sw_fire;
         sw_pend <= sw_set || (sw_pend && !sw_done);
      end
   end

   // sticky underrun flag, set dominates clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else
         flag_q <= flag_evt || (flag_q && !flag_clr);
   end

   // R6
   follow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.en && !ctl_q.trig_en) |=> (out_q == $past(hold_q)));

   // R8
   frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.en |=> $stable(out_q));

   // R10
   cal_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.en |=> $stable(ctl_q.cal));

   // R11
   mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.en || ctl_q.cal) |=> $stable(mode_q));

   // R9
   sw_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_done && !sw_set) |=> !sw_pend);

   // R12
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_evt |=> flag_q);

   // R12
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !flag_evt) |=> !flag_q);

endmodule

// File: rtl/dacfe_top.sv
`timescale 1ns/1ps
module dacfe_top
   import dacfe_pkg::*;
#(
   parameter int DW     = 12,
   parameter int NTRIG  = 16,
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NTRIG-1:0]  trig_in,
   input  logic [1:0]        udr_evt,
   output logic [DW-1:0]     dac_out1,
   output logic [DW-1:0]     dac_out2
);

   localparam int NCH = 2;

   logic              ctl_we, mode_we, sw_we, flag_we;
   logic [NCH-1:0]    hold_we;
   logic [DW-1:0]     hold_val [NCH];
   logic [NTRIG-1:0]  trig_last;

   chan_ctl_t         ctl_q   [NCH];
   logic [MODE_W-1:0] mode_q  [NCH];
   logic [NCH-1:0]    sw_pend;
   logic [NCH-1:0]    flag_q;
   logic [DW-1:0]     hold_q  [NCH];
   logic [DW-1:0]     out_q   [NCH];

   dacfe_wrdec #(.DW(DW), .NCH(NCH)) wrdec_i (
      .addr     (bus_addr),
      .wen      (bus_wen),
      .wdata    (bus_wdata),
      .ctl_we   (ctl_we),
      .mode_we  (mode_we),
      .sw_we    (sw_we),
      .flag_we  (flag_we),
      .hold_we  (hold_we),
      .hold_val (hold_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         trig_last <= '0;
      else
         trig_last <= trig_in;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dacfe_chan #(.DW(DW), .NTRIG(NTRIG), .MODE_W(MODE_W)) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_we    (ctl_we),
         .ctl_wr    (chan_ctl_t'(bus_wdata[c*CH_STRIDE +: CTL_W])),
         .mode_we   (mode_we),
         .mode_wr   (bus_wdata[c*CH_STRIDE +: MODE_W]),
         .sw_set    (sw_we && bus_wdata[c]),
         .flag_clr  (flag_we && bus_wdata[c*CH_STRIDE]),
         .flag_evt  (udr_evt[c]),
         .hold_we   (hold_we[c]),
         .hold_wr   (hold_val[c]),
         .trig_now  (trig_in),
         .trig_last (trig_last),
         .ctl_q     (ctl_q[c]),
         .mode_q    (mode_q[c]),
         .sw_pend   (sw_pend[c]),
         .flag_q    (flag_q[c]),
         .hold_q    (hold_q[c]),
         .out_q     (out_q[c])
      );
   end

   assign dac_out1 = out_q[0];
   assign dac_out2 = out_q[1];

   // present a held sample in the layout of a data view
   function automatic logic [15:0] pack_view(fmt_e f, logic [DW-1:0] v);
      case (f)
         FMT_RIGHT: return 16'(v);
         FMT_LEFT:  return 16'(v) << (16 - DW);
         FMT_BYTE:  return 16'(v[DW-1 -: 8]);
         default:   return '0;
      endcase
   endfunction

   logic [3:0] rd_grp;
   fmt_e       rd_fmt;
   assign rd_grp = bus_addr[7:4];
   assign rd_fmt = fmt_e'(bus_addr[3:2]);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[1:0] == 2'b00) begin
         case (rd_grp)
            GRP_REGS: begin
               for (int c = 0; c < NCH; c++) begin
                  case (bus_addr)
                     OFS_CTRL:  bus_rdata[c*CH_STRIDE +: CTL_W]  = ctl_q[c];
                     OFS_MODE:  bus_rdata[c*CH_STRIDE +: MODE_W] = mode_q[c];
                     OFS_SWTRG: bus_rdata[c]                     = sw_pend[c];
                     default:   bus_rdata[c*CH_STRIDE]           = flag_q[c];
                  endcase
               end
            end
            4'h1:     bus_rdata[15:0] = pack_view(rd_fmt, hold_q[0]);
            4'h2:     bus_rdata[15:0] = pack_view(rd_fmt, hold_q[1]);
            GRP_DUAL: begin
               if (rd_fmt == FMT_BYTE)
                  bus_rdata[15:0] = {pack_view(rd_fmt, hold_q[1])[7:0],
                                     pack_view(rd_fmt, hold_q[0])[7:0]};
               else
                  bus_rdata = {pack_view(rd_fmt, hold_q[1]), pack_view(rd_fmt, hold_q[0])};
            end
            GRP_OUT: begin
               if (rd_fmt == FMT_RIGHT)     bus_rdata[DW-1:0] = out_q[0];
               else if (rd_fmt == FMT_LEFT) bus_rdata[DW-1:0] = out_q[1];
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   if (DW < 8 || DW > 16) begin : g_bad_dw
      $error("dacfe_top: DW must lie in 8..16");
   end
   if (NTRIG < 1 || NTRIG > (1 << TSEL_W)) begin : g_bad_ntrig
      $error("dacfe_top: NTRIG must lie in 1..16");
   end
   if (MODE_W < 1 || MODE_W > CH_STRIDE) begin : g_bad_mode
      $error("dacfe_top: MODE_W out of range");
   end

endmodule

// File: tb/dacfe_top_tb_top.sv
`timescale 1ns/1ps
module dacfe_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] trig_in = '0;
   logic [1:0]  udr_evt = '0;
   logic [11:0] dac_out1, dac_out2;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [11:0] exp_v1 [$];
   string       exp_t1 [$];
   logic [11:0] exp_v2 [$];
   string       exp_t2 [$];
   logic [11:0] last1 = '0;
   logic [11:0] last2 = '0;

   always #4 clk = ~clk;

   dacfe_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
      .udr_evt(udr_evt), .dac_out1(dac_out1), .dac_out2(dac_out2)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_out(input int ch, input logic [11:0] v, input string tag);
      if (ch == 1) begin exp_v1.push_back(v); exp_t1.push_back(tag); end
      else         begin exp_v2.push_back(v); exp_t2.push_back(tag); end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor side: every output change must match the next prediction
   always @(negedge clk) begin
      if (rst_n) begin
         if (dac_out1 !== last1) begin
            if (exp_v1.size() == 0) check(32'(dac_out1), 32'(last1), "unexpected dac_out1 change");
            else check(32'(dac_out1), 32'(exp_v1.pop_front()), exp_t1.pop_front());
            last1 = dac_out1;
         end
         if (dac_out2 !== last2) begin
            if (exp_v2.size() == 0) check(32'(dac_out2), 32'(last2), "unexpected dac_out2 change");
            else check(32'(dac_out2), 32'(exp_v2.pop_front()), exp_t2.pop_front());
            last2 = dac_out2;
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      idle(3);
      rst_n = 1'b1;

      // R1 reset values
      rd(8'h00, r); check(r, 32'h0, "R1 control after reset");
      rd(8'h0C, r); check(r, 32'h0, "R1 flags after reset");
      check(32'({dac_out2, dac_out1}), 32'h0, "R1 outputs after reset");

      wr(8'h00, 32'h0001_0001);                    // both channels on, untriggered

      expect_out(1, 12'hABC, "R2 R6 right view ch1");
      wr(8'h10, 32'hFFFF_FABC); idle(2);
      expect_out(1, 12'h567, "R3 left view ch1");
      wr(8'h14, 32'hFFFF_5678); idle(2);
      expect_out(1, 12'h5A0, "R4 byte view ch1");
      wr(8'h18, 32'hFFFF_FF5A); idle(2);
      expect_out(2, 12'h9A0, "R4 byte view ch2");
      wr(8'h28, 32'h0000_009A); idle(2);

      // R5 dual views
      expect_out(1, 12'h123, "R5 dual right ch1");
      expect_out(2, 12'hDEF, "R5 dual right ch2");
      wr(8'h30, 32'h0DEF_0123); idle(2);
      expect_out(1, 12'h654, "R5 dual left ch1");
      expect_out(2, 12'h987, "R5 dual left ch2");
      wr(8'h34, 32'h9870_6540); idle(2);
      expect_out(1, 12'h7E0, "R5 dual byte ch1");
      expect_out(2, 12'h3C0, "R5 dual byte ch2");
      wr(8'h38, 32'hFFFF_3C7E); idle(2);

      // R8 disabled channel keeps its output
      wr(8'h00, 32'h0000_0001);
      wr(8'h20, 32'h0000_0111); idle(4);
      check(32'(dac_out2), 32'h3C0, "R8 ch2 disabled output frozen");

      // R7 triggered mode, select input 5
      wr(8'h00, 32'h0000_0017);
      wr(8'h10, 32'h0000_0222); idle(3);
      check(32'(dac_out1), 32'h7E0, "R7 no trigger no update");
      @(negedge clk); trig_in[3] = 1'b1;
      @(negedge clk); trig_in[3] = 1'b0;
      idle(2);
      check(32'(dac_out1), 32'h7E0, "R7 wrong trigger ignored");
      expect_out(1, 12'h222, "R7 selected trigger edge");
      @(negedge clk); trig_in[5] = 1'b1;
      @(negedge clk); trig_in[5] = 1'b0;
      idle(2);

      // R9 software trigger
      wr(8'h10, 32'h0000_0333);
      expect_out(1, 12'h333, "R9 software trigger copy");
      wr(8'h08, 32'h0000_0001);
      bus_addr = 8'h08;
      #1 check(32'(bus_rdata[0]), 32'h1, "R9 pending after write");
      check(32'(dac_out1), 32'h222, "R9 output before copy");
      @(negedge clk); #1;
      check(32'(bus_rdata[0]), 32'h1, "R9 pending in copy cycle");
      check(32'(dac_out1), 32'h333, "R9 output after copy");
      @(negedge clk); #1;
      check(32'(bus_rdata[0]), 32'h0, "R9 pending self-cleared");

      // R10 calibration guard
      wr(8'h00, 32'h0000_0057);
      rd(8'h00, r); check(r, 32'h0000_0017, "R10 cal ignored while enabled");
      wr(8'h00, 32'h0000_0040);
      rd(8'h00, r); check(r, 32'h0000_0000, "R10 cal ignored in disabling write");
      wr(8'h00, 32'h0000_0040);
      rd(8'h00, r); check(r, 32'h0000_0040, "R10 cal accepted when disabled");

      // R11 mode guard
      wr(8'h04, 32'h0000_0005);
      rd(8'h04, r); check(r, 32'h0, "R11 mode ignored in calibration");
      wr(8'h00, 32'h0000_0000);
      wr(8'h04, 32'h0000_0005);
      rd(8'h04, r); check(r, 32'h0000_0005, "R11 mode accepted when idle");
      wr(8'h00, 32'h0000_0001);
      wr(8'h04, 32'h0003_0002);
      rd(8'h04, r); check(r, 32'h0003_0005, "R11 ch1 locked ch2 accepted");

      // R12 underrun flag
      @(negedge clk); udr_evt = 2'b01;
      @(negedge clk); udr_evt = 2'b00;
      rd(8'h0C, r); check(r, 32'h0000_0001, "R12 flag set by event");
      wr(8'h0C, 32'h0001_0000);
      rd(8'h0C, r); check(r, 32'h0000_0001, "R12 other channel clear ignored");
      wr(8'h0C, 32'h0000_0001);
      rd(8'h0C, r); check(r, 32'h0, "R12 write one clears");
      @(negedge clk);
      bus_addr = 8'h0C; bus_wdata = 32'h0001_0000; bus_wen = 1'b1; udr_evt = 2'b10;
      @(negedge clk);
      bus_wen = 1'b0; udr_evt = 2'b00;
      rd(8'h0C, r); check(r, 32'h0001_0000, "R12 set wins over clear");

      // R13 read-only outputs
      wr(8'h40, 32'h0000_0FFF);
      wr(8'h44, 32'h0000_0FFF);
      rd(8'h40, r); check(r, 32'h0000_0333, "R13 out1 readback");
      rd(8'h44, r); check(r, 32'h0000_03C0, "R13 out2 readback");
      check(32'({dac_out2, dac_out1}), 32'h03C0_333, "R13 outputs unchanged");

      idle(3);
      check(32'(exp_v1.size() + exp_v2.size()), 32'h0, "scoreboard drained");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule